// File: doc/BRIEF.md
# PWM Period Timebase

This block is the common period reference for a multi-phase PWM. It divides the system clock by a programmable power of two to produce a PWM tick. Each tick advances a 5-bit period counter. The phase generators that sit next to it compare their own phase offsets against that counter.

The block runs in one of two modes. As the master, the counter wraps when it reaches the programmed period value and a sync pulse is sent out, so other timebases can follow. As a slave, the counter ignores the period value. It restarts only when a rising edge arrives on the external sync input. It waits at zero after enabling until the first such edge, and it holds at its maximum value if the edges stop. All pins are plain level or strobe controls. There is no streaming data path, so no valid/ready handshake applies.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, count, tick, period_end and sync_out are all zero.
- R2: While either enable is high, tick is high for one clock in every 2^P clocks (P = prescale). The divider is cleared while disabled, so after enabling, count first changes on the 2^P-th rising clock edge.
- R3: In master mode (slave_mode = 0) count advances by one on each tick. On the tick where count has reached the period value N, period_end is high for that cycle and count returns to 0. A full period is 2^P * (N + 1) clocks.
- R4: A period field of 0 acts as 1, so the period is never shorter than two ticks.
- R5: In master mode, sync_out goes high on the clock after each period_end and stays high for exactly one tick interval (2^P clocks).
- R6: When both enables are low, tick is 0 at once, and on the next clock count and sync_out are 0. They stay at 0 for as long as both enables remain low.
- R7: In slave mode, count stays at 0 after enabling until the first rising edge of sync_in is seen.
- R8: In slave mode, a rising edge of sync_in passes through two synchronizer flops and one edge flop. period_end is high on the cycle after the second rising clock edge following the change, and count is 0 after the third. Holding sync_in high does not restart the count again.
- R9: In slave mode, count saturates at 31 when no sync edge arrives, rather than wrapping.
- R10: sync_in has no effect in master mode or while disabled. sync_out stays low in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_a | input | 1 | Phase A enable; the block runs when either enable is high |
| en_b | input | 1 | Phase B enable |
| slave_mode | input | 1 | 1 = follow sync_in, 0 = master with terminal count |
| prescale | input | 2 | Divider exponent P; tick every 2^P clocks |
| period | input | 5 | Terminal count N for master mode |
| sync_in | input | 1 | Asynchronous period restart from a master |
| count | output | 5 | Current period counter value |
| tick | output | 1 | One-clock strobe when the counter may advance |
| period_end | output | 1 | One-clock strobe at the end of each period |
| sync_out | output | 1 | Master sync, high for one tick interval after period end |

## Verification
Several properties are checked on every clock cycle:
- the counter holds still between ticks and steps by exactly one on a non-terminal master tick;
- every period_end is followed by a zero count;
- disabling zeroes the counter and sync output;
- a slave counter at 31 can only stay there or restart;
- sync_out stays low in slave mode.

Other behaviours depend on counting clocks across whole periods, so only the bench scenarios can show them: the exact period and sync widths for each prescale and period pair, the delay to the first tick after enabling, the three-edge latency from sync_in to the counter restart, and the fact that a held sync_in acts only once.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int CNT_W_DEF = 5;
  localparam int PS_W_DEF  = 2;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] prescale,
  output logic            tick
);
  localparam int DIV_W = (2 ** PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  // limit = 2^prescale - 1, built as a thermometer code
  always_comb begin
    limit = '0;
    for (int i = 0; i < DIV_W; i++) begin
      limit[i] = (i < int'(prescale));
    end
  end

  assign tick = run && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_tb_sync_edge.sv
module pwm_tb_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, stable_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      stable_q <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
      prev_q   <= stable_q;
    end
  end

  assign rise = stable_q && !prev_q;
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slave,
  input  logic             tick,
  input  logic             sync_rise,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             period_end,
  output logic             sync_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             armed_q;
  logic             sync_q;
  logic             master_end;

  assign term       = (period == '0) ? CNT_ONE : period;
  assign master_end = !slave && tick && (cnt_q >= term);
  assign period_end = run && (slave ? sync_rise : master_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (slave) begin
      sync_q <= 1'b0;
      if (sync_rise) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (tick && armed_q && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      armed_q <= 1'b0;
      if (tick) begin
        cnt_q  <= master_end ? '0 : cnt_q + 1'b1;
        sync_q <= master_end;
      end
    end
  end

  assign count    = cnt_q;
  assign sync_out = sync_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PS_W  = PS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             slave_mode,
  input  logic [PS_W-1:0]  prescale,
  input  logic [CNT_W-1:0] period,
  input  logic             sync_in,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             period_end,
  output logic             sync_out
);
  logic run;
  logic sync_rise;

  assign run = en_a || en_b;

  pwm_tb_prescaler #(.PS_W(PS_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .prescale (prescale),
    .tick     (tick)
  );

  pwm_tb_sync_edge u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sync_in),
    .rise     (sync_rise)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .slave      (slave_mode),
    .tick       (tick),
    .sync_rise  (sync_rise),
    .period     (period),
    .count      (count),
    .period_end (period_end),
    .sync_out   (sync_out)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 5,
  parameter int PS_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_a,
  input logic             en_b,
  input logic             slave_mode,
  input logic [PS_W-1:0]  prescale,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic             period_end,
  input logic             sync_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_a || en_b) && !tick && !slave_mode) |=> $stable(count));

  a_r2_undivided_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_a || en_b) && (prescale == '0)) |-> tick);

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && (en_a || en_b) && tick && !period_end)
      |=> (count == $past(count) + 1'b1));

  a_r3_end_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (count == '0));

  a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_a || en_b) |=> ((count == '0) && !sync_out));

  a_r6_off_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_a || en_b) |-> !tick);

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && (en_a || en_b) && (count == CNT_MAX))
      |=> ((count == CNT_MAX) || (count == '0)));

  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> !sync_out);
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_a       (en_a),
  .en_b       (en_b),
  .slave_mode (slave_mode),
  .prescale   (prescale),
  .count      (count),
  .tick       (tick),
  .period_end (period_end),
  .sync_out   (sync_out)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_a = 1'b0, en_b = 1'b0, slave_mode = 1'b0, sync_in = 1'b0;
  logic [1:0] prescale = 2'd0;
  logic [4:0] period = 5'd1;
  logic [4:0] count;
  logic       tick, period_end, sync_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
    .slave_mode(slave_mode), .prescale(prescale), .period(period),
    .sync_in(sync_in), .count(count), .tick(tick),
    .period_end(period_end), .sync_out(sync_out)
  );

  // prescale, period, expected clocks per period
  localparam int VEC [6][3] = '{
    '{0, 1, 2}, '{0, 3, 4}, '{1, 3, 8},
    '{2, 5, 24}, '{3, 31, 256}, '{1, 0, 4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cyc(3);
    chk(count == 0 && !tick && !period_end && !sync_out, "R1 in reset", count, 0);
    rst_n = 1'b1;
    cyc(1);
    chk(count == 0 && !tick && !period_end && !sync_out, "R1 after reset", count, 0);

    // R3 R4 R5: table of master configurations
    for (int v = 0; v < 6; v++) begin
      int d, eff, p, hi, mx;
      en_a = 0; en_b = 0; slave_mode = 0;
      prescale = 2'(VEC[v][0]);
      period = 5'(VEC[v][1]);
      cyc(2);
      en_b = 1;
      d = 1 << VEC[v][0];
      eff = (VEC[v][1] == 0) ? 1 : VEC[v][1];
      p = 0;
      while (!period_end && p < 600) begin cyc(1); p++; end
      p = 0; hi = 0; mx = 0;
      do begin
        cyc(1); p++;
        if (sync_out) hi++;
        if (int'(count) > mx) mx = int'(count);
      end while (!period_end && p < 600);
      chk(p == VEC[v][2], "R3/R4 period length", p, VEC[v][2]);
      chk(hi == d, "R5 sync_out width", hi, d);
      chk(mx == eff, "R3/R4 terminal count", mx, eff);
    end

    // R6 disable clears state
    prescale = 2'd2; period = 5'd5; en_b = 1; cyc(7);
    en_b = 0; en_a = 0;
    chk(!tick, "R6 tick drops at once", tick, 0);
    cyc(1);
    chk(count == 0 && !sync_out, "R6 cleared", count, 0);
    cyc(5);
    chk(count == 0 && !sync_out && !tick, "R6 held", count, 0);

    // R2 divider restarts from zero on enable
    en_a = 1;
    cyc(3);
    chk(count == 0 && tick, "R2 first tick window", count, 0);
    cyc(1);
    chk(count == 1, "R2 first step on 4th edge", count, 1);
    begin
      int nt = 0;
      for (int i = 0; i < 16; i++) begin cyc(1); if (tick) nt++; end
      chk(nt == 4, "R2 tick rate", nt, 4);
    end

    // R10 master ignores sync_in
    en_a = 0; prescale = 2'd0; period = 5'd31; cyc(2);
    en_a = 1;
    begin
      int g = 0;
      while (count != 5 && g < 100) begin cyc(1); g++; end
    end
    sync_in = 1;
    cyc(4);
    chk(count == 9, "R10 master ignores sync", count, 9);
    sync_in = 0;

    // R7 slave parks at zero
    en_a = 0; cyc(2);
    slave_mode = 1; en_a = 1;
    cyc(20);
    chk(count == 0, "R7 parked before sync", count, 0);
    chk(!sync_out, "R10 slave sync_out low", sync_out, 0);

    // R8 sync latency and edge-only action
    sync_in = 1;
    cyc(2);
    chk(period_end, "R8 period_end timing", period_end, 1);
    cyc(1);
    chk(count == 0, "R8 count restarted", count, 0);
    cyc(1);
    chk(count == 1, "R8 counting after sync", count, 1);

    // R9 saturation with sync held high (no second edge)
    cyc(40);
    chk(count == 31, "R9 saturates", count, 31);
    sync_in = 0; cyc(3);
    sync_in = 1; cyc(3);
    chk(count == 0, "R8 second edge restarts", count, 0);
    sync_in = 0;

    // R10 sync while disabled does not arm the slave
    en_a = 0; cyc(2);
    sync_in = 1; cyc(3);
    sync_in = 0; cyc(4);
    en_b = 1;
    cyc(10);
    chk(count == 0, "R10 disabled sync ignored", count, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule